// File: doc/BRIEF.md
# Mode-Controlled Bus Program Counter

This block holds the instruction address of a small stack machine. The counter sits on the same data bus as the rest of the datapath. A 3-bit mode code tells it what to do on each rising clock edge. It can clear to zero, take the value present on the bus, or count up by one. In one mode it places its value on the bus, and in every other mode it stays off the bus.

The shared bus is split into three signals: an input word, an output word and an output-enable. This keeps the block synthesizable, and an enclosing level can turn these signals into a tri-state pin if it needs one. The output word always shows the current count, and the enable decides whether that word reaches the bus. Fetching instructions, stack handling, branch decoding and memory access belong to other blocks.

Top module: `pc_bus_counter`

## Requirements
- R1: One rising edge with `rst` high leaves the count (seen on `bus_out`) at 0x00, and `bus_oe` is low while `rst` is high and `mode` is not 2.
- R2: The synchronous reset wins over every mode. Asserting `rst` with any mode clears the count at that edge, even when the mode would load or increment.
- R3: Mode code 3'd0 clears the count to 0x00 at the next rising edge.
- R4: Mode code 3'd1 copies `bus_in` into the count at the next rising edge.
- R5: Mode code 3'd2 leaves the count unchanged across the edge, and `bus_out` equals the count during that cycle.
- R6: Mode code 3'd3 leaves the count unchanged, and `bus_oe` is low.
- R7: Mode codes 3'd5, 3'd6 and 3'd7 act like mode 3. The count holds and `bus_oe` is low.
- R8: Mode code 3'd4 adds one to the count at the next rising edge. 0xFF wraps to 0x00, and there is no carry output.
- R9: `bus_oe` is high in exactly the cycles whose `mode` is 3'd2. It follows `mode` combinationally in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset, clears the count |
| mode | input | 3 | Operation code: 0 clear, 1 load, 2 drive, 3 idle, 4 increment, 5-7 idle |
| bus_in | input | WIDTH (8) | Word sampled from the shared bus |
| bus_out | output | WIDTH (8) | Current count, offered to the shared bus |
| bus_oe | output | 1 | High when the counter should drive the bus |

## Verification
The properties assume that `mode` and `bus_in` hold known values at every sampled edge once reset is released. A load or increment check would otherwise compare against an unknown value. The bench changes inputs only at falling edges and never leaves an input unknown after the first reset. It also keeps `rst` high across the first edge, so every property whose look-back reaches the previous cycle starts from a defined count.

// File: rtl/pc_bus_pkg.sv
package pc_bus_pkg;

    // Raw bus-side mode codes; the values are the external encoding.
    typedef enum logic [2:0] {
        MODE_CLEAR = 3'd0,
        MODE_LOAD  = 3'd1,
        MODE_DRIVE = 3'd2,
        MODE_IDLE  = 3'd3,
        MODE_STEP  = 3'd4
    } pc_mode_e;

    // Internal register operation after decoding.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_INC   = 2'd3
    } pc_op_e;

    localparam int MODE_W = 3;

endpackage

// File: rtl/pc_mode_decode.sv
module pc_mode_decode
    import pc_bus_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output pc_op_e            op,
    output logic              drive
);

    always_comb begin
        op    = OP_HOLD;
        drive = 1'b0;
        case (pc_mode_e'(mode))
            MODE_CLEAR: op    = OP_CLEAR;
            MODE_LOAD:  op    = OP_LOAD;
            MODE_DRIVE: drive = 1'b1;
            MODE_STEP:  op    = OP_INC;
            default:    op    = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
    import pc_bus_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  pc_op_e           op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] bus_word,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    always_comb begin
        case (op)
            OP_CLEAR: nxt = ZERO;
            OP_LOAD:  nxt = bus_word;
            OP_INC:   nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/pc_bus_counter.sv
module pc_bus_counter
    import pc_bus_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe
);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } pc_state_t;

    pc_state_t        state_d;
    pc_state_t        state_q;
    pc_op_e           op;
    logic             drive;
    logic [WIDTH-1:0] count_nx;

    pc_mode_decode u_decode (
        .mode  (mode),
        .op    (op),
        .drive (drive)
    );

    pc_next_calc #(.WIDTH(WIDTH)) u_next (
        .op       (op),
        .cur      (state_q.count),
        .bus_word (bus_in),
        .nxt      (count_nx)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.count = '0;
        end else begin
            state_d.count = count_nx;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign bus_out = state_q.count;
    assign bus_oe  = drive;

endmodule

// File: rtl/pc_bus_counter_chk.sv
module pc_bus_counter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       mode,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> bus_out == '0);

    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd0 |=> bus_out == '0);

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd1 |=> bus_out == $past(bus_in));

    a_r5_drive_holds: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd2 |=> $stable(bus_out));

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd3 |=> $stable(bus_out));

    a_r7_spare_codes_hold: assert property (@(posedge clk) disable iff (rst)
        (mode >= 3'd5) |=> $stable(bus_out));

    a_r8_increment: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd4 |=> bus_out == WIDTH'($past(bus_out) + WIDTH'(1)));

    a_r9_oe_only_drive: assert property (@(posedge clk) disable iff (rst)
        bus_oe == (mode == 3'd2));

endmodule

bind pc_bus_counter pc_bus_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .bus_in  (bus_in),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
);

// File: tb/pc_bus_counter_bench.sv
module pc_bus_counter_bench;

    localparam int PERIOD = 10;
    localparam int W      = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   mode = 3'd3;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe;

    int n_vec  = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    pc_bus_counter #(.WIDTH(W)) u_pc_bus_counter (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive inputs at a falling edge, check the enable, then let one rising edge pass.
    task automatic apply(input logic r, input logic [2:0] m, input logic [W-1:0] b,
                         input string oe_tag, input logic oe_exp);
        @(negedge clk);
        rst = r; mode = m; bus_in = b;
        #1;
        check(oe_tag, int'(bus_oe), int'(oe_exp));
        @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] model(input logic [2:0] m, input logic [W-1:0] cur,
                                           input logic [W-1:0] b);
        case (m)
            3'd0:    return '0;
            3'd1:    return b;
            3'd4:    return W'((int'(cur) + 1) % 256);
            default: return cur;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R8";
            default: return "R7";
        endcase
    endfunction

    initial begin
        // Reset state (R1)
        apply(1'b1, 3'd3, 8'hA5, "R1", 1'b0);
        check("R1", int'(bus_out), 0);

        // Reset priority over load and increment (R2)
        apply(1'b0, 3'd1, 8'h77, "R9", 1'b0);
        check("R4", int'(bus_out), 'h77);
        apply(1'b1, 3'd4, 8'h00, "R1", 1'b0);
        check("R2", int'(bus_out), 0);
        apply(1'b0, 3'd1, 8'h3C, "R9", 1'b0);
        apply(1'b1, 3'd1, 8'h55, "R1", 1'b0);
        check("R2", int'(bus_out), 0);

        // Exhaustive sweep: every start value against every mode code
        for (int v = 0; v < 256; v++) begin
            for (int m = 0; m < 8; m++) begin
                logic [W-1:0] exp_v;
                logic [W-1:0] other;
                other = ~W'(v);
                apply(1'b0, 3'd1, W'(v), "R9", 1'b0);
                check("R4", int'(bus_out), v);
                exp_v = model(3'(m), W'(v), other);
                apply(1'b0, 3'(m), other, "R9", (m == 2));
                check(tag_of(3'(m)), int'(bus_out), int'(exp_v));
            end
        end

        // Wrap at the top (R8)
        apply(1'b0, 3'd1, 8'hFE, "R9", 1'b0);
        apply(1'b0, 3'd4, 8'h00, "R9", 1'b0);
        check("R8", int'(bus_out), 'hFF);
        apply(1'b0, 3'd4, 8'h00, "R9", 1'b0);
        check("R8", int'(bus_out), 'h00);

        // Drive mode shows the count in the same cycle (R5)
        apply(1'b0, 3'd1, 8'h9D, "R9", 1'b0);
        @(negedge clk);
        mode = 3'd2; bus_in = 8'h00;
        #1;
        check("R9", int'(bus_oe), 1);
        check("R5", int'(bus_out), 'h9D);
        mode = 3'd6;
        #1;
        check("R7", int'(bus_oe), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule